// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a full-duplex synchronous serial port for a processor subsystem. It has one shift path that sends words and a second that receives them. The processor writes an 11-bit control word to set up both paths. It writes a 16-bit word to start a transmission, and it reads the most recently received word from the same data register.

Each path chooses its bit clock and its word-start strobe separately, and for each of the two the choice is active or passive. An active source is made inside the block from the system clock through a programmable divider. A passive source arrives on a pin, and clock pins are synchronized into the system clock domain. Each path also sets its own word length (8 or 16 bits) and its own bit order. A loopback input feeds the transmit path back into the receive path so the port can be tested without external wiring. Two flags tell the processor when a received word is waiting and when the transmit register can accept a new word.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `tx_empty` is 1 and `rx_full` is 0. Every serial clock, strobe and data output is 0. The control word is all zeros, which selects passive sources, 16-bit words, MSB-first order, divide-by-2 and no input pacing.
- R2: Control word fields:
  - bit 0: receive length, 1 = 8 bits
  - bit 1: transmit length, 1 = 8 bits
  - bit 2: receive clock, 1 = active
  - bit 3: transmit clock, 1 = active
  - bit 4: receive strobe, 1 = active
  - bit 5: transmit strobe, 1 = active
  - bit 6: transmit order, 1 = LSB first
  - bits 8:7: clock rate
  - bit 9: receive pacing
  - bit 10: receive order, 1 = LSB first
- R3: The active bit clock has a period of 2*(rate+1) system cycles. It appears on `oclk_o` when the transmit clock is active and on `iclk_o` when the receive clock is active. Otherwise that output stays 0.
- R4: With an active transmit strobe, `oload_o` goes high at a falling bit-clock edge, but only when a word is waiting. It stays high for one bit period. The first data bit is driven at the next falling edge. Back-to-back words therefore repeat every length+1 bit periods.
- R5: Transmit bits change at falling bit-clock edges in the selected length and order. An 8-bit word is taken from the low byte of the written value. `sdout` is 0 whenever no word is being shifted.
- R6: In passive mode the bit clock comes from the pin. The strobe pin is sampled at a rising bit-clock edge. The word then starts at the following falling edge: transmit drives its first bit there, and receive samples its first bit at the rising edge after it.
- R7: Received bits are sampled at rising bit-clock edges in the selected order. An 8-bit word is right-justified in `rx_rdata` with the upper byte zero.
- R8: With an active receive strobe, `iload_o` pulses for one bit period at a falling edge whenever the receive path is idle, so frames follow one another continuously. When pacing (bit 9) is 1, no pulse is issued while `rx_full` is 1.
- R9: While `loop_en` is 1, the receive path takes the transmit data, the transmit bit clock and the transmit word start. `sdin` and the receive pins have no effect.
- R10: Writing the data register clears `tx_empty` on the next cycle. Moving the word into the shifter sets `tx_empty`. A completed receive word sets `rx_full`. A read pulse clears `rx_full`, unless a word completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 11 | Control word value |
| tx_we | input | 1 | Data register write strobe |
| tx_wdata | input | 16 | Word to transmit |
| rx_re | input | 1 | Data register read strobe |
| rx_rdata | output | 16 | Last received word |
| rx_full | output | 1 | Received word waiting |
| tx_empty | output | 1 | Transmit register free |
| loop_en | input | 1 | Internal loopback enable |
| sdin | input | 1 | Serial data in |
| iclk_i | input | 1 | Passive receive bit clock |
| iload_i | input | 1 | Passive receive word strobe |
| iclk_o | output | 1 | Active receive bit clock |
| iload_o | output | 1 | Active receive word strobe |
| sdout | output | 1 | Serial data out |
| oclk_i | input | 1 | Passive transmit bit clock |
| oload_i | input | 1 | Passive transmit word strobe |
| oclk_o | output | 1 | Active transmit bit clock |
| oload_o | output | 1 | Active transmit word strobe |

## Verification
The assertions watch the flag handshakes and the strobes on every cycle. They check that a write clears `tx_empty`, that a finished word raises `rx_full` with a zero upper byte in 8-bit mode, and that the end of a transmit strobe coincides with the start of shifting. They also check that paced receive strobes never start while a word is waiting. The bench's reference model checks the active transmit clock, strobe, serial data and empty flag on every clock. Bit ordering across the loopback, the passive pin timing and the continuous or paced receive framing can only be shown by the bench's scenarios.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8,
  parameter int CTL_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTL_W-1:0]  cfg_wdata,
  input  logic              tx_we,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              rx_re,
  output logic [WORD_W-1:0] rx_rdata,
  output logic              rx_full,
  output logic              tx_empty,
  input  logic              loop_en,
  input  logic              sdin,
  input  logic              iclk_i,
  input  logic              iload_i,
  output logic              iclk_o,
  output logic              iload_o,
  output logic              sdout,
  input  logic              oclk_i,
  input  logic              oload_i,
  output logic              oclk_o,
  output logic              oload_o
);
  localparam int CW = $clog2(WORD_W);
  localparam int PADW = WORD_W - SHORT_W;

  logic [CTL_W-1:0] ctl;
  always_ff @(posedge clk)
    if (!rst_n) ctl <= '0;
    else if (cfg_we) ctl <= cfg_wdata;

  wire       ilen8 = ctl[0], olen8 = ctl[1];
  wire       iclk_act = ctl[2], oclk_act = ctl[3];
  wire       iload_act = ctl[4], oload_act = ctl[5];
  wire       olsb = ctl[6], ipace = ctl[9], ilsb = ctl[10];
  wire [1:0] rate = ctl[8:7];

  // rate divider: toggles the generated clock every rate+1 cycles
  logic [1:0] dcnt;
  logic       gclk;
  wire        dwrap = dcnt >= rate;
  always_ff @(posedge clk)
    if (!rst_n) begin
      dcnt <= '0;
      gclk <= 1'b0;
    end else if (dwrap) begin
      dcnt <= '0;
      gclk <= ~gclk;
    end else dcnt <= dcnt + 2'd1;
  wire g_rise = dwrap & ~gclk;
  wire g_fall = dwrap & gclk;

  logic [2:0] isy, osy;
  always_ff @(posedge clk)
    if (!rst_n) begin
      isy <= '0;
      osy <= '0;
    end else begin
      isy <= {isy[1:0], iclk_i};
      osy <= {osy[1:0], oclk_i};
    end

  wire o_rise = oclk_act ? g_rise : (osy[1] & ~osy[2]);
  wire o_fall = oclk_act ? g_fall : (~osy[1] & osy[2]);
  wire i_rise = loop_en ? o_rise : iclk_act ? g_rise : (isy[1] & ~isy[2]);
  wire i_fall = loop_en ? o_fall : iclk_act ? g_fall : (~isy[1] & isy[2]);

  assign oclk_o = oclk_act & gclk;
  assign iclk_o = iclk_act & gclk;

  // transmit path
  logic [WORD_W-1:0] tx_hold, osh;
  logic              tx_empty_q, obusy, opend, oload_q;
  logic [CW-1:0]     ocnt;
  wire  [CW-1:0]     olast = olen8 ? CW'(SHORT_W - 1) : CW'(WORD_W - 1);
  wire               o_begin = o_fall & opend;
  wire               o_free = ~opend & ~(obusy & (ocnt != '0));
  wire               o_issue = o_fall & oload_act & o_free & ~tx_empty_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      osh <= '0;
      obusy <= 1'b0;
      opend <= 1'b0;
      oload_q <= 1'b0;
      ocnt <= '0;
    end else if (o_begin) begin
      osh <= (olen8 & ~olsb) ? {tx_hold[SHORT_W-1:0], {PADW{1'b0}}} : tx_hold;
      obusy <= 1'b1;
      ocnt <= olast;
      opend <= 1'b0;
      oload_q <= 1'b0;
    end else begin
      if (o_fall & obusy) begin
        if (ocnt == '0) obusy <= 1'b0;
        else begin
          ocnt <= ocnt - 1'b1;
          osh <= olsb ? (osh >> 1) : (osh << 1);
        end
      end
      if (o_issue) begin
        opend <= 1'b1;
        oload_q <= 1'b1;
      end else if (o_rise & ~oload_act & oload_i) opend <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      tx_hold <= '0;
      tx_empty_q <= 1'b1;
    end else if (tx_we) begin
      tx_hold <= tx_wdata;
      tx_empty_q <= 1'b0;
    end else if (o_begin) tx_empty_q <= 1'b1;

  wire sd_int = obusy & (olsb ? osh[0] : osh[WORD_W-1]);
  assign sdout    = sd_int;
  assign oload_o  = oload_q;
  assign tx_empty = tx_empty_q;

  // receive path
  logic [WORD_W-1:0] ish, rx_word;
  logic              ibusy, ipend, iload_q, rx_full_q;
  logic [CW-1:0]     icnt;
  wire  [CW-1:0]     ilast = ilen8 ? CW'(SHORT_W - 1) : CW'(WORD_W - 1);
  wire               din = loop_en ? sd_int : sdin;
  wire               i_begin = loop_en ? o_begin : (i_fall & ipend);
  wire               i_issue = ~loop_en & i_fall & iload_act & ~ipend & ~ibusy
                               & ~(ipace & rx_full_q);
  wire               i_done = i_rise & ibusy & (icnt == '0);
  wire [WORD_W-1:0]  ish_nx = ilsb ? {din, ish[WORD_W-1:1]} : {ish[WORD_W-2:0], din};
  wire [WORD_W-1:0]  rx_fmt = ~ilen8 ? ish_nx :
                              ilsb ? {{PADW{1'b0}}, ish_nx[WORD_W-1 -: SHORT_W]} :
                                     {{PADW{1'b0}}, ish_nx[SHORT_W-1:0]};

  always_ff @(posedge clk)
    if (!rst_n) begin
      ish <= '0;
      rx_word <= '0;
      ibusy <= 1'b0;
      ipend <= 1'b0;
      iload_q <= 1'b0;
      icnt <= '0;
    end else if (i_begin) begin
      ibusy <= 1'b1;
      icnt <= ilast;
      ipend <= 1'b0;
      iload_q <= 1'b0;
    end else begin
      if (i_rise & ibusy) begin
        ish <= ish_nx;
        if (icnt == '0) begin
          ibusy <= 1'b0;
          rx_word <= rx_fmt;
        end else icnt <= icnt - 1'b1;
      end
      if (i_issue) begin
        ipend <= 1'b1;
        iload_q <= 1'b1;
      end else if (~loop_en & i_rise & ~iload_act & iload_i) ipend <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) rx_full_q <= 1'b0;
    else if (i_done) rx_full_q <= 1'b1;
    else if (rx_re) rx_full_q <= 1'b0;

  assign rx_full  = rx_full_q;
  assign rx_rdata = rx_word;
  assign iload_o  = iload_q;

  assert_tx_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> !tx_empty);
  assert_rx_done_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    i_done |=> rx_full);
  assert_short_word_zero_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_done && ilen8) |=> (rx_rdata[WORD_W-1:SHORT_W] == '0));
  assert_strobe_end_starts_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oload_o) |-> obusy);
  assert_paced_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iload_o) |-> !($past(ipace) && $past(rx_full_q)));
endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, cfg_we = 1'b0, tx_we = 1'b0, rx_re = 1'b0, loop_en = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic [15:0] tx_wdata = '0;
  logic        sdin = 1'b0, pclk = 1'b0, pload = 1'b0;
  logic [15:0] rx_rdata;
  logic        rx_full, tx_empty, iclk_o, iload_o, sdout, oclk_o, oload_o;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
    .rx_full(rx_full), .tx_empty(tx_empty), .loop_en(loop_en), .sdin(sdin),
    .iclk_i(pclk), .iload_i(pload), .iclk_o(iclk_o), .iload_o(iload_o),
    .sdout(sdout), .oclk_i(pclk), .oload_i(pload), .oclk_o(oclk_o), .oload_o(oload_o));

  int compared = 0, mismatched = 0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the active transmit side
  logic        model_on = 1'b0;
  logic [10:0] mcfg;
  logic [15:0] mhold, mword;
  logic        mg, mpend, mload, mbusy, mempty;
  int          mdc, midx;

  function automatic int tlen();
    return mcfg[1] ? 8 : 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcfg = '0; mhold = '0; mword = '0; mg = 0; mpend = 0; mload = 0;
      mbusy = 0; mempty = 1; mdc = 0; midx = 0;
    end else begin
      logic wrap, fall, free, issue;
      wrap = (mdc >= int'(mcfg[8:7]));
      fall = wrap && mg;
      if (wrap) begin mdc = 0; mg = !mg; end else mdc++;
      if (mcfg[3] && fall) begin
        free  = !mpend && !(mbusy && midx != tlen() - 1);
        issue = mcfg[5] && free && !mempty;
        if (mpend) begin
          mword = mhold; mempty = 1; mbusy = 1; midx = 0; mpend = 0; mload = 0;
        end else begin
          if (mbusy) begin
            if (midx == tlen() - 1) mbusy = 0; else midx++;
          end
          if (issue) begin mpend = 1; mload = 1; end
        end
      end
      if (tx_we) begin mhold = tx_wdata; mempty = 0; end
      if (cfg_we) mcfg = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic ebit;
      ebit = !mbusy ? 1'b0 : mcfg[6] ? mword[midx] : mword[tlen() - 1 - midx];
      chk("R3 oclk_o", oclk_o, mcfg[3] ? mg : 1'b0);
      chk("R4 oload_o", oload_o, mload);
      chk("R5 sdout", sdout, ebit);
      chk("R10 tx_empty", tx_empty, mempty);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; model_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask
  task automatic wcfg(input logic [10:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wtx(input logic [15:0] v);
    @(negedge clk); tx_we = 1; tx_wdata = v;
    @(negedge clk); tx_we = 0;
  endtask
  task automatic rdrx();
    @(negedge clk); rx_re = 1;
    @(negedge clk); rx_re = 0;
  endtask
  task automatic wait_rx(input int lim);
    for (int k = 0; k < lim && !rx_full; k++) @(negedge clk);
  endtask
  task automatic wait_empty(input int lim);
    for (int k = 0; k < lim && !tx_empty; k++) @(negedge clk);
  endtask
  task automatic clk_period(output int p);
    logic prev, found;
    prev = oclk_o; found = 0;
    for (int k = 0; k < 100 && !found; k++) begin
      @(negedge clk); if (oclk_o && !prev) found = 1; prev = oclk_o;
    end
    p = 0; found = 0;
    for (int k = 0; k < 100 && !found; k++) begin
      @(negedge clk); p++; if (oclk_o && !prev) found = 1; prev = oclk_o;
    end
  endtask
  task automatic count_iload(input int cycles, output int n);
    logic prev;
    prev = iload_o; n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); if (iload_o && !prev) n++; prev = iload_o;
    end
  endtask
  task automatic pbit(input logic ld, input logic d, output logic so);
    @(negedge clk); pclk = 0; pload = ld; sdin = d;
    repeat (7) @(negedge clk);
    pclk = 1;
    repeat (4) @(negedge clk);
    so = sdout;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p, n;
    logic so;
    logic [15:0] obits;
    do_reset();
    @(negedge clk);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 outputs", {iclk_o, iload_o, sdout, oclk_o, oload_o}, 0);
    chk("R1 rx_rdata", rx_rdata, 0);

    // loopback, active transmit, 16-bit MSB first; sdin held high and ignored (R9)
    model_on = 1; loop_en = 1; sdin = 1;
    wcfg(11'h028);
    wtx(16'h1234);
    wait_rx(400);
    chk("R9 loop word", rx_rdata, 16'h1234);
    chk("R10 rx_full set", rx_full, 1);
    rdrx();
    chk("R10 rx_full cleared", rx_full, 0);
    wtx(16'hA5C3);
    wait_empty(100);
    wtx(16'h0F0F);
    wait_rx(400);
    chk("R4 first of pair", rx_rdata, 16'hA5C3);
    rdrx();
    wait_rx(400);
    chk("R4 second of pair", rx_rdata, 16'h0F0F);
    rdrx();

    // 8-bit, both LSB first, rate 3
    wcfg(11'h5EB);
    wtx(16'hBE5A);
    wait_rx(800);
    chk("R7 8-bit lsb", rx_rdata, 16'h005A);
    rdrx();
    clk_period(p);
    chk("R3 period rate3", p, 8);
    chk("R3 iclk_o passive", iclk_o, 0);

    // transmit MSB first, receive LSB first: byte arrives reversed
    wcfg(11'h5AB);
    wtx(16'h0001);
    wait_rx(800);
    chk("R2 order split", rx_rdata, 16'h0080);
    rdrx();
    wcfg(11'h128);
    clk_period(p);
    chk("R3 period rate2", p, 6);

    // both paths passive from pins
    do_reset();
    loop_en = 0;
    wcfg(11'h042);
    wtx(16'h00C6);
    pbit(1, 0, so);
    for (int i = 0; i < 16; i++) begin
      pbit(0, (16'h9D3E >> (15 - i)) & 1'b1, so);
      obits[i] = so;
    end
    repeat (6) @(negedge clk);
    chk("R6 passive rx word", rx_rdata, 16'h9D3E);
    chk("R6 passive tx byte", obits[7:0], 8'hC6);
    chk("R5 idle sdout zero", obits[15:8], 8'h00);
    chk("R10 tx taken", tx_empty, 1);

    // active receive, paced then free running
    do_reset();
    model_on = 1; loop_en = 0; sdin = 1;
    wcfg(11'h215);
    wait_rx(400);
    chk("R7 upper byte zero", rx_rdata, 16'h00FF);
    count_iload(200, n);
    chk("R8 paced no strobe", n, 0);
    chk("R3 iclk_o active", iclk_o | oclk_o, iclk_o);
    wcfg(11'h015);
    count_iload(200, n);
    chk("R8 free running strobes", n >= 5, 1);
    rdrx();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule